// File: doc/BRIEF.md
# Ethernet Transmit Framer with Padding, FCS and Gap Timing

This block sits on the transmit path between a frame source and the MAC-to-PHY data pins. It takes frame bytes one at a time, starting with the destination address, through a valid/ready handshake. The first byte of each frame carries two option flags. The block sends the bytes out on an 8-bit symbol stream, one byte per line byte time. It zero-fills short frames up to the Ethernet minimum, can add a CRC-32 frame check sequence to each frame on its own, and keeps the line idle for 96 bit times between frames. A speed input selects how many clock cycles make up one byte time, which sets line rate and gap duration for 100 Mbps or 10 Mbps operation.

The source must keep each frame's next byte ready when the block asks for it. The block pulls one byte per byte time while a frame's data is flowing. It stops pulling while it inserts padding, the check sequence or the gap. A new frame may be offered right after the previous last byte. The block holds it back until the gap has run out, so minimum-size frames go out back to back at full line rate.

Top module: `eth_txp_framer`

## Requirements
- R1: A byte slot lasts DIV_FAST clock cycles when `spd_100` is 1 and DIV_SLOW cycles when it is 0. The first slot boundary is the clock edge DIV-1 cycles after reset release. `tx_en` and `txd` change only on slot boundaries.
- R2: Frame bytes appear on `txd` in the order accepted, with `tx_en` high, one byte per slot. The first byte of a frame is accepted at the first slot boundary while idle with `s_valid` high. It appears on the outputs right after that boundary. `txd` is 0 whenever `tx_en` is low.
- R3: When the padding flag of a frame is 1 and the frame has fewer than MIN_DATA (60) bytes, zero bytes follow the data until MIN_DATA bytes have been sent.
- R4: When the padding flag is 0, a short frame is sent at its own length with no fill bytes.
- R5: When the check-sequence flag is 1, four bytes follow data and padding. They hold the complement of a CRC-32 over data and padding, using polynomial 0x04C11DB7 and an all-ones preset. The result is sent least significant bit first, so the lowest-order byte on the wire carries the highest-order CRC bits, bit-reversed.
- R6: When the check-sequence flag is 0, the frame ends after its data (and padding) with no check bytes.
- R7: Every frame is followed by exactly 12 idle byte slots (96 bit times). A frame already waiting starts in the 13th slot after the previous frame's final byte.
- R8: During reset `tx_en`, `txd` and `s_ready` are 0.
- R9: The option flags are taken only from the first byte of a frame. Their values on later bytes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| spd_100 | input | 1 | 1 selects 100 Mbps byte timing, 0 selects 10 Mbps |
| s_valid | input | 1 | Source byte valid |
| s_ready | output | 1 | Byte accepted this cycle when high together with s_valid |
| s_data | input | 8 | Source frame byte |
| s_last | input | 1 | Marks the last data byte of a frame |
| s_fcs_en | input | 1 | Append check sequence (sampled on first byte) |
| s_pad_en | input | 1 | Pad short frame (sampled on first byte) |
| tx_en | output | 1 | Transmit enable toward the PHY |
| txd | output | 8 | Transmit byte toward the PHY |

## Verification
A wrong slot counter shows up within one byte time as a `tx_en` or `txd` edge at the wrong cycle. A wrong length count or padding flag shows as a missing or extra zero byte at the end of a short frame, at the slot where the data should stop. A corrupted CRC register stays hidden until the four check bytes at the frame's end. The first of them then carries a wrong value. A gap counter fault shows as the next frame starting one or more slots early or late, which the cycle-by-cycle comparison catches in that very slot.

// File: rtl/eth_txp_pkg.sv
package eth_txp_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DATA,
      ST_PAD,
      ST_FCS,
      ST_GAP
   } txp_state_e;

   localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;

   function automatic logic [31:0] bit_rev32(input logic [31:0] x);
      logic [31:0] r;
      for (int i = 0; i < 32; i++) r[i] = x[31-i];
      return r;
   endfunction

endpackage

// File: rtl/eth_txp_slot_timer.sv
module eth_txp_slot_timer #(
   parameter int DIV_FAST = 20,
   parameter int DIV_SLOW = 200
) (
   input  logic clk,
   input  logic rst,
   input  logic spd_100,
   output logic slot
);
   localparam int CW = $clog2(DIV_SLOW);

   initial begin
      assert (DIV_FAST >= 2) else $error("DIV_FAST must be at least 2");
      assert (DIV_SLOW >= DIV_FAST) else $error("DIV_SLOW below DIV_FAST");
   end

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] lim;

   assign lim  = spd_100 ? CW'(DIV_FAST - 1) : CW'(DIV_SLOW - 1);
   assign slot = (cnt_q >= lim);

   always_ff @(posedge clk) begin
      if (rst)       cnt_q <= '0;
      else if (slot) cnt_q <= '0;
      else           cnt_q <= cnt_q + 1'b1;
   end

   AST_SLOT_NOT_TWICE: assert property (@(posedge clk) disable iff (rst)
      slot |=> !slot); // R1

endmodule

// File: rtl/eth_txp_crc32.sv
module eth_txp_crc32 (
   input  logic        clk,
   input  logic        rst,
   input  logic        start,
   input  logic        adv,
   input  logic [7:0]  din,
   output logic [31:0] fcs
);
   import eth_txp_pkg::*;

   localparam logic [31:0] POLY_REF = bit_rev32(CRC_POLY);

   logic [31:0] crc_q;
   logic [31:0] chain [9];

   assign chain[0] = start ? 32'hFFFF_FFFF : crc_q;

   for (genvar i = 0; i < 8; i++) begin : g_bit
      assign chain[i+1] = {1'b0, chain[i][31:1]} ^
                          ({32{chain[i][0] ^ din[i]}} & POLY_REF);
   end

   always_ff @(posedge clk) begin
      if (rst)      crc_q <= 32'hFFFF_FFFF;
      else if (adv) crc_q <= chain[8];
   end

   assign fcs = ~crc_q;

endmodule

// File: rtl/eth_txp_gap_timer.sv
module eth_txp_gap_timer #(
   parameter int GAP_SLOTS = 12
) (
   input  logic clk,
   input  logic rst,
   input  logic active,
   input  logic step,
   output logic done
);
   localparam int GW = $clog2(GAP_SLOTS + 1);

   initial begin
      assert (GAP_SLOTS >= 1) else $error("GAP_SLOTS must be positive");
   end

   logic [GW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst || !active) cnt_q <= '0;
      else if (step)      cnt_q <= cnt_q + 1'b1;
   end

   assign done = active && step && (cnt_q == GW'(GAP_SLOTS - 1));

   AST_GAP_BOUND: assert property (@(posedge clk) disable iff (rst)
      active |-> cnt_q < GW'(GAP_SLOTS)); // R7

endmodule

// File: rtl/eth_txp_framer.sv
module eth_txp_framer #(
   parameter int DIV_FAST = 20,
   parameter int DIV_SLOW = 200,
   parameter int MIN_DATA = 60,
   parameter int IFG_BITS = 96
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       spd_100,
   input  logic       s_valid,
   output logic       s_ready,
   input  logic [7:0] s_data,
   input  logic       s_last,
   input  logic       s_fcs_en,
   input  logic       s_pad_en,
   output logic       tx_en,
   output logic [7:0] txd
);
   import eth_txp_pkg::*;

   localparam int GAP_SLOTS = IFG_BITS / 8;
   localparam int LW        = $clog2(MIN_DATA + 1);
   localparam logic [LW-1:0] MIN_L = LW'(MIN_DATA);

   initial begin
      assert (MIN_DATA >= 1) else $error("MIN_DATA must be positive");
      assert (IFG_BITS % 8 == 0) else $error("IFG_BITS must be whole bytes");
   end

   txp_state_e    st_q, st_d;
   logic [LW-1:0] len_q, len_d, len_inc;
   logic [1:0]    fi_q, fi_d;
   logic          pad_q, pad_d, fcs_q, fcs_d;
   logic [7:0]    ob_q, ob_d;
   logic          ov_q, ov_d;
   logic          byte_slot;
   logic          crc_start, crc_adv;
   logic [7:0]    crc_din;
   logic [31:0]   fcs_w;
   logic          gap_done;

   eth_txp_slot_timer #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) u_slot (
      .clk(clk), .rst(rst), .spd_100(spd_100), .slot(byte_slot));

   eth_txp_crc32 u_crc (
      .clk(clk), .rst(rst), .start(crc_start), .adv(crc_adv),
      .din(crc_din), .fcs(fcs_w));

   eth_txp_gap_timer #(.GAP_SLOTS(GAP_SLOTS)) u_gap (
      .clk(clk), .rst(rst), .active(st_q == ST_GAP), .step(byte_slot),
      .done(gap_done));

   function automatic txp_state_e after_data(input logic [LW-1:0] n,
                                             input logic pad, input logic fcs);
      if (pad && (n < MIN_L)) return ST_PAD;
      else if (fcs)           return ST_FCS;
      else                    return ST_GAP;
   endfunction

   assign len_inc = (len_q == MIN_L) ? len_q : len_q + 1'b1;

   always_comb begin
      st_d      = st_q;
      len_d     = len_q;
      fi_d      = fi_q;
      pad_d     = pad_q;
      fcs_d     = fcs_q;
      ob_d      = ob_q;
      ov_d      = ov_q;
      s_ready   = 1'b0;
      crc_start = 1'b0;
      crc_adv   = 1'b0;
      crc_din   = 8'h00;
      if (byte_slot) begin
         unique case (st_q)
            ST_IDLE: begin
               s_ready = 1'b1;
               fi_d    = 2'd0;
               if (s_valid) begin
                  ov_d      = 1'b1;
                  ob_d      = s_data;
                  crc_start = 1'b1;
                  crc_adv   = 1'b1;
                  crc_din   = s_data;
                  len_d     = LW'(1);
                  pad_d     = s_pad_en;
                  fcs_d     = s_fcs_en;
                  st_d      = s_last ? after_data(LW'(1), s_pad_en, s_fcs_en) : ST_DATA;
               end else begin
                  ov_d = 1'b0;
                  ob_d = 8'h00;
               end
            end
            ST_DATA: begin
               s_ready = 1'b1;
               if (s_valid) begin
                  ov_d    = 1'b1;
                  ob_d    = s_data;
                  crc_adv = 1'b1;
                  crc_din = s_data;
                  len_d   = len_inc;
                  if (s_last) st_d = after_data(len_inc, pad_q, fcs_q);
               end else begin
                  ov_d = 1'b0;
                  ob_d = 8'h00;
               end
            end
            ST_PAD: begin
               ov_d    = 1'b1;
               ob_d    = 8'h00;
               crc_adv = 1'b1;
               len_d   = len_inc;
               if (len_inc >= MIN_L) st_d = fcs_q ? ST_FCS : ST_GAP;
            end
            ST_FCS: begin
               ov_d = 1'b1;
               ob_d = fcs_w[{fi_q, 3'b000} +: 8];
               fi_d = fi_q + 2'd1;
               if (fi_q == 2'd3) st_d = ST_GAP;
            end
            ST_GAP: begin
               ov_d = 1'b0;
               ob_d = 8'h00;
               if (gap_done) st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q  <= ST_IDLE;
         len_q <= '0;
         fi_q  <= 2'd0;
         pad_q <= 1'b0;
         fcs_q <= 1'b0;
         ob_q  <= 8'h00;
         ov_q  <= 1'b0;
      end else begin
         st_q  <= st_d;
         len_q <= len_d;
         fi_q  <= fi_d;
         pad_q <= pad_d;
         fcs_q <= fcs_d;
         ob_q  <= ob_d;
         ov_q  <= ov_d;
      end
   end

   assign tx_en = ov_q;
   assign txd   = ob_q;

   AST_SLOT_ONLY: assert property (@(posedge clk) disable iff (rst)
      !$past(byte_slot) |-> $stable(tx_en) && $stable(txd)); // R1
   AST_FIRST_BYTE: assert property (@(posedge clk) disable iff (rst)
      (st_q == ST_IDLE) && s_valid && s_ready |=> tx_en && (txd == $past(s_data))); // R2
   AST_PAD_ZERO: assert property (@(posedge clk) disable iff (rst)
      (st_q == ST_PAD) && byte_slot |=> tx_en && (txd == 8'h00)); // R3
   AST_PAD_REACHED: assert property (@(posedge clk) disable iff (rst)
      (st_q == ST_FCS) && pad_q |-> len_q >= MIN_L); // R3
   AST_FCS_FOUR: assert property (@(posedge clk) disable iff (rst)
      (st_q == ST_GAP) && ($past(st_q) == ST_FCS) |-> $past(fi_q) == 2'd3); // R5
   AST_GAP_IDLE: assert property (@(posedge clk) disable iff (rst)
      (st_q == ST_GAP) && byte_slot |=> !tx_en); // R7

endmodule

// File: tb/eth_txp_framer_tb.sv
`timescale 1ns/1ps
module eth_txp_framer_tb_top;

   localparam int DIVF = 20;
   localparam int DIVS = 200;
   localparam int MINL = 60;
   localparam int GAPS = 12;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       spd_100 = 1'b1;
   logic       s_valid = 1'b0;
   logic       s_ready;
   logic [7:0] s_data = 8'h00;
   logic       s_last = 1'b0;
   logic       s_fcs_en = 1'b0;
   logic       s_pad_en = 1'b0;
   logic       tx_en;
   logic [7:0] txd;

   always #2 clk = ~clk;

   eth_txp_framer dut_i (
      .clk(clk), .rst(rst), .spd_100(spd_100), .s_valid(s_valid),
      .s_ready(s_ready), .s_data(s_data), .s_last(s_last),
      .s_fcs_en(s_fcs_en), .s_pad_en(s_pad_en), .tx_en(tx_en), .txd(txd));

   typedef struct {
      logic       v;
      logic [7:0] b;
      string      tag;
   } slot_t;

   slot_t q[$];
   slot_t cur;
   int    errors = 0;
   int    checks = 0;
   int    bcnt = 0;
   int    cyc = 0;
   bit    finished = 0;

   function automatic logic [31:0] ref_crc(input logic [7:0] a[$]);
      logic [31:0] c = 32'hFFFF_FFFF;
      logic fb;
      foreach (a[i]) begin
         for (int k = 0; k < 8; k++) begin
            fb = c[31] ^ a[i][k];
            c  = {c[30:0], 1'b0};
            if (fb) c = c ^ 32'h04C1_1DB7;
         end
      end
      return ~c;
   endfunction

   // reference slot model: one slot per DIV cycles from reset release
   always @(posedge clk) begin
      cyc++;
      if (rst) begin
         bcnt = 0;
         cur  = '{1'b0, 8'h00, "R8"};
      end else if (bcnt >= (spd_100 ? DIVF : DIVS) - 1) begin
         bcnt = 0;
         if (q.size() > 0) cur = q.pop_front();
         else              cur = '{1'b0, 8'h00, "R2"};
      end else begin
         bcnt++;
      end
   end

   always @(negedge clk) begin
      if (!finished) begin
         if (rst) begin
            checks++;
            if (tx_en !== 1'b0 || txd !== 8'h00 || s_ready !== 1'b0) begin
               errors++;
               $display("FAIL R8 reset outputs: tx_en=%b txd=%h s_ready=%b expected 0 00 0",
                        tx_en, txd, s_ready);
            end
         end else begin
            checks++;
            if (tx_en !== cur.v || txd !== cur.b) begin
               errors++;
               $display("FAIL %s (slot timing R1) at cycle %0d: tx_en=%b txd=%h expected tx_en=%b txd=%h",
                        cur.tag, cyc, tx_en, txd, cur.v, cur.b);
            end
         end
      end
   end

   always @(posedge clk) begin
      if (cyc > 180000 && !finished) begin
         finished = 1;
         errors++;
         checks++;
         $display("FAIL watchdog expired at cycle %0d", cyc);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   task automatic send_byte();
      forever begin
         if (s_ready) begin
            @(negedge clk);
            break;
         end
         @(negedge clk);
      end
   endtask

   task automatic send_frame(input int n, input bit pad, input bit fcs, input int seed);
      logic [7:0] body[$];
      logic [31:0] f;
      string ft, gt;
      int dlen;
      for (int i = 0; i < n; i++) body.push_back(8'((seed * 37 + i * 13 + 5) & 8'hFF));
      dlen = n;
      for (int i = 0; i < n; i++) q.push_back('{1'b1, body[i], "R2"});
      if (pad) begin
         while (body.size() < MINL) begin
            body.push_back(8'h00);
            q.push_back('{1'b1, 8'h00, "R3"});
         end
      end
      ft = (!pad && dlen < MINL) ? "R4 R5 R9" : "R5 R9";
      gt = fcs ? "R7" : "R6 R7";
      if (!pad && dlen < MINL) gt = {"R4 ", gt};
      if (fcs) begin
         f = ref_crc(body);
         for (int j = 0; j < 4; j++) begin
            logic [7:0] ob;
            for (int k = 0; k < 8; k++) ob[k] = f[31 - (8 * j + k)];
            q.push_back('{1'b1, ob, ft});
         end
      end
      for (int g = 0; g < GAPS; g++) q.push_back('{1'b0, 8'h00, gt});
      for (int i = 0; i < n; i++) begin
         s_valid  = 1'b1;
         s_data   = body[i];
         s_last   = (i == n - 1);
         // R9: later bytes carry the opposite flags
         s_pad_en = (i == 0) ? pad : ~pad;
         s_fcs_en = (i == 0) ? fcs : ~fcs;
         send_byte();
      end
      s_valid = 1'b0;
      s_last  = 1'b0;
   endtask

   task automatic drain();
      while (q.size() > 0) @(negedge clk);
      repeat (2 * DIVS) @(negedge clk);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst = 1'b0;
      // fast mode, assorted options
      send_frame(10, 1, 1, 1);   // R3 R5
      send_frame(60, 1, 1, 2);   // exactly minimum, no fill
      send_frame(64, 0, 1, 3);   // R5 long frame
      send_frame(20, 0, 1, 4);   // R4 short unpadded with check bytes
      send_frame(20, 1, 0, 5);   // R3 R6
      send_frame(1, 1, 1, 6);    // single-byte frame
      send_frame(5, 0, 0, 7);    // R4 R6 bare frame
      // back-to-back minimum frames, R7
      send_frame(60, 0, 1, 8);
      send_frame(60, 0, 1, 9);
      send_frame(60, 0, 1, 10);
      drain();
      // slow mode, R1 R7
      spd_100 = 1'b0;
      send_frame(12, 1, 1, 11);
      send_frame(3, 0, 1, 12);
      drain();
      spd_100 = 1'b1;
      send_frame(30, 1, 1, 13);
      drain();
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule